// File: doc/BRIEF.md
# Posted-Write Clock-Domain Register Bridge

This block sits between a fast bus-clock register port and a slower functional-clock timer register file. Writes to the ten registers that live in the functional domain are carried across the clock boundary in the background. Each of those registers owns a pending flag. A flag is set when its register is written and is cleared once the value has been applied on the functional side. Software reads all ten flags from one read-only status word. Registers that need no crossing are kept on the bus side and update at once.

Software selects one of two write modes at runtime. In posted mode the bus write finishes in the same cycle, and the crossing happens later. In stalling mode the bus ready signal stays low until the value has reached the functional domain. The functional side applies every write in the same order the bus issued it. A soft reset request travels through that same ordered path. A reset-done flag goes low when the request is made and returns high once the functional side has carried out the reset.

The functional register file is not part of this block. It receives a one-cycle write strobe with register number and data, plus a one-cycle soft-reset strobe.

Top module: `posted_sync_bridge`

## Requirements
- R1: After hardware reset, the pending word (offset 0x34) reads 0, the system status word (0x14) reads 1 (bit 0 = reset done), the interface control word (0x40) reads 0x4 (bit 2 = posted mode on), and offset 0x00 reads the ID_VALUE parameter.
- R2: In posted mode, a write to a crossing register is accepted with no stall. Its value later appears on the functional side as one f_we pulse carrying that register's number and data.
- R3: The pending bit positions are fixed, and f_reg carries the same number as the bit. Bit 0 is control (0x24), bit 1 is counter (0x28), bit 2 is load (0x2C), bit 3 is trigger (0x30), bit 4 is match (0x38), bit 5 is positive tick increment (0x48), bit 6 is negative tick increment (0x4C), bit 7 is tick count (0x50), bit 8 is overflow mask set (0x54) and bit 9 is overflow mask count (0x58). The bit reads 1 directly after the write and reads 0 once the value has landed.
- R4: In posted mode, a write to a crossing register whose pending bit is still set is dropped, and wr_err pulses for one bus clock. A second soft reset request made while an earlier one is still pending is handled the same way.
- R5: The functional side applies crossing writes in issue order, so a trigger write never lands before an earlier load write.
- R6: When bit 2 of 0x40 is written as 0 (stalling mode), a write to a crossing register holds req_ready low until the value has been applied on the functional side. When the write completes, its pending bit reads 0.
- R7: Writes to the direct registers (0x10 configuration, 0x18 status, 0x1C interrupt enable, 0x20 wake-up enable) take effect at once and read back unchanged. They produce no functional-side write and set no pending bit.
- R8: Writing 0x40 with bit 1 set requests a soft reset. The direct registers clear, posted mode is forced on, and bit 0 of 0x14 reads 0 until f_soft_rst has pulsed once in issue order; it then reads 1 again.
- R9: Writes to the read-only offsets 0x34 (pending word), 0x00 (ID) and 0x14 (system status) have no effect.
- R10: Reading a crossing register returns the last value the bridge accepted for it. A dropped write does not change this value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain reset, active low, asynchronous assert |
| fclk | input | 1 | Functional clock |
| frst_n | input | 1 | Functional-domain reset, active low |
| req_valid | input | 1 | Bus access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (8) | Byte offset of the register |
| req_wdata | input | DW (32) | Write data |
| req_ready | output | 1 | Access completes on a clock edge where valid and ready are both high |
| rdata | output | DW (32) | Read data for req_addr, combinational |
| wr_err | output | 1 | One-cycle pulse when a posted write is dropped |
| f_we | output | 1 | Functional-side write strobe |
| f_reg | output | SW (4) | Number of the register being written (same as its pending bit) |
| f_wdata | output | DW (32) | Functional-side write data |
| f_soft_rst | output | 1 | Functional-side soft reset strobe |

## Verification
The bench uses the default parameters: a 32-bit data path and two synchronizer stages. The functional clock runs at one third of the bus clock rate. Because a single crossing then takes many bus cycles, back-to-back bus writes reliably find earlier transfers still in flight. This makes three cases reachable: a write that collides with a pending register, a queue holding several registers at once, and a stall of several cycles in stalling mode. Soft reset is tested both alone and with a second request issued while the first is still pending.

// File: rtl/psync_pkg.sv
package psync_pkg;
    localparam int AW       = 8;
    localparam int NSYNC    = 10;
    localparam int NSLOT    = NSYNC + 1;          // last slot carries the soft reset
    localparam int SW       = $clog2(NSLOT);
    localparam logic [SW-1:0] RST_SLOT = SW'(NSYNC);

    localparam logic [AW-1:0] OFF_ID   = 8'h00;
    localparam logic [AW-1:0] OFF_CFG  = 8'h10;
    localparam logic [AW-1:0] OFF_SYS  = 8'h14;
    localparam logic [AW-1:0] OFF_STAT = 8'h18;
    localparam logic [AW-1:0] OFF_IEN  = 8'h1c;
    localparam logic [AW-1:0] OFF_WEN  = 8'h20;
    localparam logic [AW-1:0] OFF_PEND = 8'h34;
    localparam logic [AW-1:0] OFF_CAP  = 8'h3c;
    localparam logic [AW-1:0] OFF_IFC  = 8'h40;

    typedef struct packed {
        logic          hit;
        logic [SW-1:0] slot;
    } slot_hit_t;

    // offset -> pending bit number; bit order is software visible
    function automatic slot_hit_t sync_lookup(input logic [AW-1:0] off);
        slot_hit_t r;
        r.hit  = 1'b1;
        r.slot = '0;
        case (off)
            8'h24:   r.slot = SW'(0);
            8'h28:   r.slot = SW'(1);
            8'h2c:   r.slot = SW'(2);
            8'h30:   r.slot = SW'(3);
            8'h38:   r.slot = SW'(4);
            8'h48:   r.slot = SW'(5);
            8'h4c:   r.slot = SW'(6);
            8'h50:   r.slot = SW'(7);
            8'h54:   r.slot = SW'(8);
            8'h58:   r.slot = SW'(9);
            default: r.hit  = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/psync_sync2.sv
module psync_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/psync_queue.sv
module psync_queue #(
    parameter int DEPTH = 11,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } qst_t;

    qst_t         q_q, q_d;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d = q_q;
        if (push) q_d.wr = bump(q_q.wr);
        if (pop)  q_d.rd = bump(q_q.rd);
        case ({push, pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[q_q.wr] <= push_data;
    end

    assign head  = mem_q[q_q.rd];
    assign empty = (q_q.cnt == '0);
endmodule

// File: rtl/psync_xfer.sv
module psync_xfer #(
    parameter int DW     = 32,
    parameter int SW     = 4,
    parameter int STAGES = 2
) (
    input  logic          bclk,
    input  logic          brst_n,
    input  logic          launch,
    input  logic [SW-1:0] l_slot,
    input  logic [DW-1:0] l_data,
    output logic          busy,
    output logic          done,
    output logic [SW-1:0] done_slot,
    input  logic          fclk,
    input  logic          frst_n,
    output logic          f_pulse,
    output logic [SW-1:0] f_slot,
    output logic [DW-1:0] f_data
);
    typedef struct packed {
        logic          req_tog;
        logic          busy;
        logic [SW-1:0] slot;
        logic [DW-1:0] data;
    } src_t;

    typedef struct packed {
        logic          seen;
        logic          ack_tog;
        logic          pulse;
        logic [SW-1:0] slot;
        logic [DW-1:0] data;
    } dst_t;

    src_t s_q, s_d;
    dst_t d_q, d_d;
    logic req_s, ack_s;

    psync_sync2 #(.STAGES(STAGES)) u_req_sync (
        .clk(fclk), .rst_n(frst_n), .d(s_q.req_tog), .q(req_s));
    psync_sync2 #(.STAGES(STAGES)) u_ack_sync (
        .clk(bclk), .rst_n(brst_n), .d(d_q.ack_tog), .q(ack_s));

    // bus side: slot/data stay frozen from launch until the ack returns
    always_comb begin
        s_d  = s_q;
        done = s_q.busy && (ack_s == s_q.req_tog);
        if (done) s_d.busy = 1'b0;
        if (launch && !s_q.busy) begin
            s_d.busy    = 1'b1;
            s_d.req_tog = ~s_q.req_tog;
            s_d.slot    = l_slot;
            s_d.data    = l_data;
        end
    end

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) s_q <= '0;
        else         s_q <= s_d;
    end

    // functional side: one pulse per request toggle, ack toggles back
    always_comb begin
        d_d       = d_q;
        d_d.pulse = 1'b0;
        if (req_s != d_q.seen) begin
            d_d.seen    = req_s;
            d_d.ack_tog = ~d_q.ack_tog;
            d_d.pulse   = 1'b1;
            d_d.slot    = s_q.slot;
            d_d.data    = s_q.data;
        end
    end

    always_ff @(posedge fclk or negedge frst_n) begin
        if (!frst_n) d_q <= '0;
        else         d_q <= d_d;
    end

    assign busy      = s_q.busy;
    assign done_slot = s_q.slot;
    assign f_pulse   = d_q.pulse;
    assign f_slot    = d_q.slot;
    assign f_data    = d_q.data;
endmodule

// File: rtl/posted_sync_bridge.sv
module posted_sync_bridge
    import psync_pkg::*;
#(
    parameter int          DW          = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] ID_VALUE    = 32'h0051_7A02
) (
    input  logic          bclk,
    input  logic          brst_n,
    input  logic          fclk,
    input  logic          frst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic [DW-1:0] rdata,
    output logic          wr_err,
    output logic          f_we,
    output logic [SW-1:0] f_reg,
    output logic [DW-1:0] f_wdata,
    output logic          f_soft_rst
);
    typedef struct packed {
        logic [NSLOT-1:0] pend;
        logic             posted;
        logic             np_wait;
        logic [SW-1:0]    np_slot;
        logic             err;
        logic [DW-1:0]    cfg;
        logic [DW-1:0]    stat;
        logic [DW-1:0]    ien;
        logic [DW-1:0]    wen;
    } bus_st_t;

    bus_st_t       st_q, st_d;
    logic [DW-1:0] hold_q [NSLOT];
    slot_hit_t     lk;
    logic          wr, hold_we, push, pop, q_empty, launch;
    logic [SW-1:0] push_slot, q_head, xf_slot, fx_slot;
    logic [DW-1:0] launch_data, fx_data;
    logic          xf_busy, xf_done, fx_pulse;
    logic          posted_w;
    logic [NSLOT-1:0] pend_w;

    assign lk = sync_lookup(req_addr);
    assign wr = req_valid && req_write;

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        req_ready = 1'b1;
        push      = 1'b0;
        push_slot = lk.slot;
        hold_we   = 1'b0;
        if (xf_done) st_d.pend[xf_slot] = 1'b0;
        if (wr) begin
            if (lk.hit) begin
                if (st_q.posted) begin
                    if (st_q.pend[lk.slot]) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.pend[lk.slot] = 1'b1;
                        push    = 1'b1;
                        hold_we = 1'b1;
                    end
                end else if (st_q.np_wait) begin
                    req_ready = !st_q.pend[st_q.np_slot];
                    if (req_ready) st_d.np_wait = 1'b0;
                end else begin
                    req_ready = 1'b0;
                    if (!st_q.pend[lk.slot]) begin
                        st_d.pend[lk.slot] = 1'b1;
                        st_d.np_wait       = 1'b1;
                        st_d.np_slot       = lk.slot;
                        push    = 1'b1;
                        hold_we = 1'b1;
                    end
                end
            end else begin
                case (req_addr)
                    OFF_CFG:  st_d.cfg  = req_wdata;
                    OFF_STAT: st_d.stat = req_wdata;
                    OFF_IEN:  st_d.ien  = req_wdata;
                    OFF_WEN:  st_d.wen  = req_wdata;
                    OFF_IFC: begin
                        st_d.posted = req_wdata[2];
                        if (req_wdata[1]) begin
                            if (st_q.pend[NSYNC]) begin
                                st_d.err = 1'b1;
                            end else begin
                                st_d.pend[NSYNC] = 1'b1;
                                push      = 1'b1;
                                push_slot = RST_SLOT;
                                st_d.cfg    = '0;
                                st_d.stat   = '0;
                                st_d.ien    = '0;
                                st_d.wen    = '0;
                                st_d.posted = 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) begin
            st_q        <= '0;
            st_q.posted <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) begin
            for (int i = 0; i < NSLOT; i++) hold_q[i] <= '0;
        end else if (hold_we) begin
            hold_q[lk.slot] <= req_wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (lk.hit) begin
            rdata = hold_q[lk.slot];
        end else begin
            case (req_addr)
                OFF_ID:   rdata = DW'(ID_VALUE);
                OFF_CFG:  rdata = st_q.cfg;
                OFF_SYS:  rdata = DW'(!st_q.pend[NSYNC]);
                OFF_STAT: rdata = st_q.stat;
                OFF_IEN:  rdata = st_q.ien;
                OFF_WEN:  rdata = st_q.wen;
                OFF_PEND: rdata = DW'(st_q.pend[NSYNC-1:0]);
                OFF_CAP:  rdata = '0;
                OFF_IFC:  rdata = DW'({st_q.posted, 2'b00});
                default:  rdata = '0;
            endcase
        end
    end

    psync_queue #(.DEPTH(NSLOT), .W(SW)) u_queue (
        .clk(bclk), .rst_n(brst_n), .push(push), .push_data(push_slot),
        .pop(pop), .head(q_head), .empty(q_empty));

    assign launch      = !xf_busy && !q_empty;
    assign launch_data = hold_q[q_head];
    assign pop         = xf_done;

    psync_xfer #(.DW(DW), .SW(SW), .STAGES(SYNC_STAGES)) u_xfer (
        .bclk(bclk), .brst_n(brst_n), .launch(launch), .l_slot(q_head),
        .l_data(launch_data), .busy(xf_busy), .done(xf_done), .done_slot(xf_slot),
        .fclk(fclk), .frst_n(frst_n), .f_pulse(fx_pulse), .f_slot(fx_slot),
        .f_data(fx_data));

    assign wr_err     = st_q.err;
    assign f_we       = fx_pulse && (fx_slot != RST_SLOT);
    assign f_soft_rst = fx_pulse && (fx_slot == RST_SLOT);
    assign f_reg      = fx_slot;
    assign f_wdata    = fx_data;
    assign posted_w   = st_q.posted;
    assign pend_w     = st_q.pend;
endmodule

// File: rtl/psync_checker.sv
module psync_checker
    import psync_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             req_ready,
    input logic             posted,
    input logic             wr_err,
    input logic [NSLOT-1:0] pend
);
    assert_err_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(req_valid && req_write));

    assert_stall_only_nonposted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (req_valid && req_write && !posted));

    assert_posted_never_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (posted && req_valid) |-> req_ready);

    assert_one_new_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pend & ~$past(pend)) <= 1);

    assert_pending_rise_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & ~$past(pend))) |-> $past(req_valid && req_write));
endmodule

bind posted_sync_bridge psync_checker u_psync_chk (
    .clk(bclk), .rst_n(brst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .posted(posted_w), .wr_err(wr_err), .pend(pend_w));

// File: tb/tb_posted_sync_bridge.sv
module tb_posted_sync_bridge;
    localparam logic [31:0] ID = 32'h0051_7A02;

    logic        bclk = 0, fclk = 0, brst_n = 0, frst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [7:0]  req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic        req_ready, wr_err, f_we, f_soft_rst;
    logic [31:0] rdata, f_wdata;
    logic [3:0]  f_reg;

    int total = 0, bad = 0, log_n = 0, rst_cnt = 0;
    int          log_idx [64];
    logic [31:0] log_dat [64];
    bit          finished = 0;

    always #5  bclk = ~bclk;
    always #15 fclk = ~fclk;

    posted_sync_bridge dut (
        .bclk(bclk), .brst_n(brst_n), .fclk(fclk), .frst_n(frst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rdata(rdata),
        .wr_err(wr_err), .f_we(f_we), .f_reg(f_reg), .f_wdata(f_wdata),
        .f_soft_rst(f_soft_rst));

    always @(negedge fclk) begin
        if (f_we && log_n < 64) begin
            log_idx[log_n] = int'(f_reg);
            log_dat[log_n] = f_wdata;
            log_n++;
        end
        if (f_soft_rst) rst_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d,
                          output int stalls, output logic err);
        @(negedge bclk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; stalls = 0;
        #1;
        while (!req_ready) begin
            @(negedge bclk); #1; stalls++;
        end
        @(posedge bclk);
        @(negedge bclk); #1;
        err = wr_err;
        req_valid = 0; req_write = 0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        @(negedge bclk);
        req_valid = 1; req_write = 0; req_addr = a;
        #1; d = rdata;
        req_valid = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            bread(8'h34, v);
            if (v == 0) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bread(8'h34, v); chk("R1 pending after reset", v, 0);
        bread(8'h14, v); chk("R1 reset done", v, 1);
        bread(8'h40, v); chk("R1 posted default", v, 32'h4);
        bread(8'h00, v); chk("R1 id", v, ID);
    endtask

    task automatic t_posted_basic();
        int s; logic e; logic [31:0] v; int b = log_n;
        bwrite(8'h2c, 32'h0000_1234, s, e);
        chk("R2 posted no stall", s, 0);
        chk("R2 no error", 32'(e), 0);
        bread(8'h34, v); chk("R3 load bit pending", v, 32'h4);
        wait_idle();
        chk("R2 one sink write", log_n - b, 1);
        chk("R2 sink reg", log_idx[b], 2);
        chk("R2 sink data", log_dat[b], 32'h0000_1234);
        bread(8'h2c, v); chk("R10 readback", v, 32'h0000_1234);
    endtask

    task automatic t_bit_map();
        logic [7:0] offs [10] = '{8'h24, 8'h28, 8'h2c, 8'h30, 8'h38,
                                  8'h48, 8'h4c, 8'h50, 8'h54, 8'h58};
        int s; logic e; logic [31:0] v;
        for (int i = 0; i < 10; i++) begin
            int b = log_n;
            bwrite(offs[i], 32'hA000 + 32'(i), s, e);
            bread(8'h34, v); chk("R3 bit position", v, 32'(1) << i);
            wait_idle();
            bread(8'h34, v); chk("R3 bit cleared", v, 0);
            chk("R3 sink reg number", log_idx[b], i);
            chk("R3 sink data", log_dat[b], 32'hA000 + 32'(i));
        end
    endtask

    task automatic t_collision();
        int s; logic e1, e2; logic [31:0] v; int b = log_n;
        bwrite(8'h24, 32'h1111_0001, s, e1);
        bwrite(8'h24, 32'h2222_0002, s, e2);
        chk("R4 first write accepted", 32'(e1), 0);
        chk("R4 second write flagged", 32'(e2), 1);
        bread(8'h24, v); chk("R10 dropped write not held", v, 32'h1111_0001);
        wait_idle();
        chk("R4 single sink write", log_n - b, 1);
        chk("R4 sink keeps first", log_dat[b], 32'h1111_0001);
    endtask

    task automatic t_order();
        int s; logic e; int b = log_n;
        bwrite(8'h2c, 32'h0000_00AA, s, e);
        bwrite(8'h30, 32'h0000_00BB, s, e);
        bwrite(8'h38, 32'h0000_00CC, s, e);
        bwrite(8'h24, 32'h0000_00DD, s, e);
        wait_idle();
        chk("R5 count", log_n - b, 4);
        chk("R5 load first", log_idx[b], 2);
        chk("R5 trigger second", log_idx[b+1], 3);
        chk("R5 match third", log_idx[b+2], 4);
        chk("R5 control fourth", log_idx[b+3], 0);
        chk("R5 trigger data", log_dat[b+1], 32'h0000_00BB);
    endtask

    task automatic t_nonposted();
        int s; logic e; logic [31:0] v; int b;
        bwrite(8'h40, 32'h0, s, e);
        bread(8'h40, v); chk("R6 posted off", v, 0);
        b = log_n;
        bwrite(8'h28, 32'h0BAD_F00D, s, e);
        chk("R6 stalled", 32'(s > 2), 1);
        chk("R6 landed before ready", log_n - b, 1);
        chk("R6 landed data", log_dat[b], 32'h0BAD_F00D);
        bread(8'h34, v); chk("R6 pending clear on completion", v, 0);
        bwrite(8'h40, 32'h4, s, e);
        bread(8'h40, v); chk("R6 posted restored", v, 32'h4);
    endtask

    task automatic t_direct();
        int s; logic e; logic [31:0] v; int b = log_n;
        bwrite(8'h10, 32'h0000_0015, s, e);
        bwrite(8'h18, 32'h0000_0007, s, e);
        bwrite(8'h1c, 32'h0000_0003, s, e);
        bwrite(8'h20, 32'h0000_0006, s, e);
        bread(8'h10, v); chk("R7 cfg", v, 32'h15);
        bread(8'h18, v); chk("R7 status", v, 32'h7);
        bread(8'h1c, v); chk("R7 irq enable", v, 32'h3);
        bread(8'h20, v); chk("R7 wake enable", v, 32'h6);
        bread(8'h34, v); chk("R7 no pending", v, 0);
        repeat (30) @(negedge bclk);
        chk("R7 no sink write", log_n - b, 0);
    endtask

    task automatic t_readonly();
        int s; logic e; logic [31:0] v;
        bwrite(8'h34, 32'h3FF, s, e);
        bread(8'h34, v); chk("R9 pending word read only", v, 0);
        bwrite(8'h00, 32'hFFFF_FFFF, s, e);
        bread(8'h00, v); chk("R9 id read only", v, ID);
        bwrite(8'h14, 32'h0, s, e);
        bread(8'h14, v); chk("R9 sys status read only", v, 1);
    endtask

    task automatic t_softreset();
        int s; logic e1, e2; logic [31:0] v; int r0;
        bwrite(8'h10, 32'h5, s, e1);
        r0 = rst_cnt;
        bwrite(8'h40, 32'h6, s, e1);
        bread(8'h14, v); chk("R8 reset in progress", v, 0);
        bread(8'h10, v); chk("R8 cfg cleared", v, 0);
        bread(8'h40, v); chk("R8 posted kept", v, 32'h4);
        for (int i = 0; i < 2000; i++) begin
            bread(8'h14, v);
            if (v == 1) break;
        end
        chk("R8 reset done", v, 1);
        chk("R8 one functional reset", rst_cnt - r0, 1);
        bwrite(8'h40, 32'h6, s, e1);
        bwrite(8'h40, 32'h6, s, e2);
        chk("R4 repeated reset flagged", 32'(e2), 1);
        chk("R8 first reset accepted", 32'(e1), 0);
        for (int i = 0; i < 2000; i++) begin
            bread(8'h14, v);
            if (v == 1) break;
        end
        chk("R8 only one extra reset", rst_cnt - r0, 2);
    endtask

    initial begin
        repeat (3) @(negedge bclk);
        brst_n = 1; frst_n = 1;
        t_reset();
        t_posted_basic();
        t_bit_map();
        t_collision();
        t_order();
        t_nonposted();
        t_direct();
        t_readonly();
        t_softreset();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge bclk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule